// File: doc/BRIEF.md
# Flash Instruction Cache with Next-Line Prefetch

This block sits between a processor's instruction-fetch port and a wide on-chip flash array that needs several wait states on every access. The flash returns a whole line of four 32-bit words per read. The block keeps a small set-associative store of recently used lines and replaces them least-recently-used first. It also reads the following line ahead of time while the processor works through the current one. A loop that fits in the store therefore runs without stalls once its lines are resident.

The processor holds `req_i` and a word address until `ready_o` is high in a cycle; that cycle is the accept. The addressed word appears on `rdata_o` with `rvalid_o` in the next cycle. The flash side is a pipelined line-read port with a fixed latency. A request on `fl_req_o`/`fl_addr_o` in cycle c is answered on `fl_data_i` in cycle c+WAIT_ST+1, with no handshake. A branch to a line that is neither resident nor in flight drops any pending prefetch and issues its own read at once. `flush_i` empties the store in one cycle.

Top module: `flash_icache`

## Requirements
- R1: During and right after reset, with no request, `ready_o`, `rvalid_o` and `fl_req_o` are low.
- R2: A request to a line that is neither resident nor in flight issues `fl_req_o` in its first cycle, with `fl_addr_o` equal to the word address shifted right by 2 (the line address). `ready_o` rises exactly WAIT_ST+1 cycles later.
- R3: The word returned in the cycle after an accept is the addressed one. Word k of a line is `fl_data_i[32k+31:32k]`, where k is word-address bits [1:0]. On a miss the word is forwarded straight from the flash data.
- R4: A request to a resident line is accepted in the cycle it is presented.
- R5: Accepting an access to line L, while the flash port is free after that cycle and line L+1 is not resident, issues a read of L+1 in the same cycle. A sequential walk therefore stalls WAIT_ST-3 cycles on entry to each new line, and a walk reading only the last word of each line stalls WAIT_ST cycles per line.
- R6: A request to a line that is neither resident nor in flight, made while a prefetch is pending, issues a demand read in its first cycle. The prefetched line is discarded and not installed.
- R7: The set index is the low log2(SETS) bits of the line address. When every way of a set is valid, a miss replaces the way least recently touched, and both hits and fills count as touches. With 2 ways, the pattern A,B,A,C,A,B,C,A in one set stalls as miss,miss,hit,miss,hit,miss,miss,miss.
- R8: `flush_i` invalidates every line in one cycle and drops any read in flight. The next access to any line is a full miss.
- R9: A two-line loop incurs stalls only on its first pass; later passes have no stall.
- R10: `rvalid_o` is high exactly in the cycles that follow an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines and drop the pending read |
| req_i | input | 1 | Fetch request, held until accepted |
| addr_i | input | ADDR_W | Word address of the fetch |
| ready_o | output | 1 | Request accepted this cycle |
| rvalid_o | output | 1 | Fetched word valid |
| rdata_o | output | 32 | Fetched instruction word |
| fl_req_o | output | 1 | Flash line read request |
| fl_addr_o | output | ADDR_W-2 | Flash line address |
| fl_data_i | input | LINE_W | Flash line data, WAIT_ST+1 cycles after the request |

## Verification
The assertions check on every cycle that a read is returned exactly one cycle after each accept and never otherwise. They also check that a demand read names the requested line and a prefetch names the line after it, that no stall runs longer than the flash latency, and that the cycle after a flush accepts nothing. They also watch internal invariants: a tag never matches twice in one set, and a hit and a fill never update the replacement order of the same set together. Only the bench scenarios can show the stall counts of a given access sequence. These include the replacement order of a full set, the dropping of a pending prefetch on a branch, the zero-stall steady state of a resident loop, and the data integrity of a complete sequential sweep.

// File: rtl/flash_icache_pkg.sv
package flash_icache_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/flash_icache_lookup.sv
module flash_icache_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  localparam int WAY_B = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_B-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = vld_i[w] & (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec_o[w]) way_o = WAY_B'(w);
  end
endmodule

// File: rtl/flash_icache_lru.sv
module flash_icache_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int SET_B = $clog2(SETS),
  localparam int WAY_B = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ta_en_i,
  input  logic [SET_B-1:0] ta_set_i,
  input  logic [WAY_B-1:0] ta_way_i,
  input  logic             tb_en_i,
  input  logic [SET_B-1:0] tb_set_i,
  input  logic [WAY_B-1:0] tb_way_i,
  input  logic [SET_B-1:0] q_set_i,
  input  logic [WAYS-1:0]  q_vld_i,
  output logic [WAY_B-1:0] victim_o
);
  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation per set
  logic [WAY_B-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_B'(w);
    end else if (clr_i) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_B'(w);
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ta_en_i && ta_set_i == SET_B'(s)) begin
            if (ta_way_i == WAY_B'(w)) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][ta_way_i]) age_q[s][w] <= age_q[s][w] + 1'b1;
          end else if (tb_en_i && tb_set_i == SET_B'(s)) begin
            if (tb_way_i == WAY_B'(w)) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][tb_way_i]) age_q[s][w] <= age_q[s][w] + 1'b1;
          end
        end
      end
    end
  end

  // empty way first, else the oldest
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!q_vld_i[w] && !found) begin
        victim_o = WAY_B'(w);
        found    = 1'b1;
      end
    end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[q_set_i][w] == WAY_B'(WAYS - 1)) victim_o = WAY_B'(w);
  end
endmodule

// File: rtl/flash_icache.sv
module flash_icache import flash_icache_pkg::*; #(
  parameter int ADDR_W  = 10,
  parameter int LINE_W  = 128,
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int WAIT_ST = 5
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  flush_i,
  input  logic                                  req_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  output logic                                  ready_o,
  output logic                                  rvalid_o,
  output logic [WORD_W-1:0]                     rdata_o,
  output logic                                  fl_req_o,
  output logic [ADDR_W-$clog2(LINE_W/32)-1:0]   fl_addr_o,
  input  logic [LINE_W-1:0]                     fl_data_i
);
  localparam int WORDS   = LINE_W / WORD_W;
  localparam int WOFF_B  = $clog2(WORDS);
  localparam int LINE_AW = ADDR_W - WOFF_B;
  localparam int SET_B   = $clog2(SETS);
  localparam int TAG_W   = LINE_AW - SET_B;
  localparam int WAY_B   = $clog2(WAYS);
  localparam int LAT     = WAIT_ST + 1;
  localparam int CNT_W   = $clog2(LAT + 1);

  logic [LINE_AW-1:0] req_line, nxt_line;
  logic [SET_B-1:0]   req_set, nxt_set, op_set;
  logic [TAG_W-1:0]   req_tag, nxt_tag;
  logic [WOFF_B-1:0]  req_wsel;

  assign req_line = addr_i[ADDR_W-1:WOFF_B];
  assign req_wsel = addr_i[WOFF_B-1:0];
  assign nxt_line = req_line + 1'b1;
  assign req_set  = req_line[SET_B-1:0];
  assign req_tag  = req_line[LINE_AW-1:SET_B];
  assign nxt_set  = nxt_line[SET_B-1:0];
  assign nxt_tag  = nxt_line[LINE_AW-1:SET_B];

  logic [WAYS-1:0]   vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [LINE_W-1:0] dat_q [SETS][WAYS];

  logic [WAYS-1:0][TAG_W-1:0] req_tags, nxt_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      req_tags[w] = tag_q[req_set][w];
      nxt_tags[w] = tag_q[nxt_set][w];
    end
  end

  logic [WAYS-1:0]  dmd_hit_vec, nxt_hit_vec;
  logic             dmd_hit, nxt_hit;
  logic [WAY_B-1:0] dmd_way, nxt_way, victim;

  flash_icache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_req (
    .vld_i(vld_q[req_set]), .tags_i(req_tags), .tag_i(req_tag),
    .hit_vec_o(dmd_hit_vec), .hit_o(dmd_hit), .way_o(dmd_way)
  );

  flash_icache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_nxt (
    .vld_i(vld_q[nxt_set]), .tags_i(nxt_tags), .tag_i(nxt_tag),
    .hit_vec_o(nxt_hit_vec), .hit_o(nxt_hit), .way_o(nxt_way)
  );

  // single outstanding flash read, fixed latency
  logic               op_busy_q;
  logic [LINE_AW-1:0] op_line_q;
  logic [CNT_W-1:0]   op_cnt_q;
  assign op_set = op_line_q[SET_B-1:0];

  logic fill_now, fwd, hit_ok, demand, pf, free_nxt, hit_touch, fill_touch;

  assign fill_now = op_busy_q & (op_cnt_q == '0);
  assign fwd      = req_i & fill_now & (op_line_q == req_line);
  // a fill into the same set may overwrite the hit way this cycle
  assign hit_ok   = dmd_hit & ~(fill_now & (op_set == req_set));
  assign ready_o  = req_i & ~flush_i & (hit_ok | fwd);
  assign demand   = req_i & ~flush_i & ~dmd_hit & ~(op_busy_q & (op_line_q == req_line));
  assign free_nxt = ~op_busy_q | fill_now;
  assign pf       = ready_o & free_nxt & ~nxt_hit & ~(fill_now & (op_line_q == nxt_line));
  assign fl_req_o  = demand | pf;
  assign fl_addr_o = demand ? req_line : nxt_line;

  assign hit_touch  = req_i & ~flush_i & hit_ok;
  assign fill_touch = fill_now & ~flush_i;

  flash_icache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .ta_en_i(hit_touch), .ta_set_i(req_set), .ta_way_i(dmd_way),
    .tb_en_i(fill_touch), .tb_set_i(op_set), .tb_way_i(victim),
    .q_set_i(op_set), .q_vld_i(vld_q[op_set]), .victim_o(victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_busy_q <= 1'b0;
      op_line_q <= '0;
      op_cnt_q  <= '0;
    end else if (flush_i) begin
      op_busy_q <= 1'b0;
    end else if (fl_req_o) begin
      op_busy_q <= 1'b1;
      op_line_q <= fl_addr_o;
      op_cnt_q  <= CNT_W'(LAT - 1);
    end else if (fill_now) begin
      op_busy_q <= 1'b0;
    end else if (op_busy_q) begin
      op_cnt_q  <= op_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_now) begin
      vld_q[op_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_now) begin
      dat_q[op_set][victim] <= fl_data_i;
      tag_q[op_set][victim] <= op_line_q[LINE_AW-1:SET_B];
    end
  end

  logic [LINE_W-1:0] sel_line;
  word_t             sel_word;
  assign sel_line = fwd ? fl_data_i : dat_q[req_set][dmd_way];
  assign sel_word = sel_line[WORD_W*int'(req_wsel) +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= ready_o;
      if (ready_o) rdata_o <= sel_word;
    end
  end
endmodule

// File: rtl/flash_icache_chk.sv
module flash_icache_chk #(
  parameter int ADDR_W  = 10,
  parameter int LINE_AW = 8,
  parameter int WAYS    = 2,
  parameter int SET_B   = 2,
  parameter int LAT     = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               req_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               ready_o,
  input logic               rvalid_o,
  input logic               fl_req_o,
  input logic [LINE_AW-1:0] fl_addr_o,
  input logic [WAYS-1:0]    dmd_hit_vec,
  input logic [WAYS-1:0]    nxt_hit_vec,
  input logic               hit_touch,
  input logic [SET_B-1:0]   req_set,
  input logic               fill_touch,
  input logic [SET_B-1:0]   op_set
);
  localparam int SC_W = $clog2(LAT + 2) + 1;

  logic [LINE_AW-1:0] a_line;
  assign a_line = addr_i[ADDR_W-1:ADDR_W-LINE_AW];

  logic [SC_W-1:0] stall_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_cnt <= '0;
    else if (flush_i || !req_i || ready_o) stall_cnt <= '0;
    else stall_cnt <= stall_cnt + 1'b1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!rvalid_o); // R1
  end

  AST_RVALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> rvalid_o); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o) |=> !rvalid_o); // R10
  AST_DEMAND_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !ready_o) |-> (req_i && fl_addr_o == a_line)); // R2
  AST_PREFETCH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && ready_o) |-> (fl_addr_o == LINE_AW'(a_line + 1'b1))); // R5
  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o && !flush_i) |-> (stall_cnt < SC_W'(LAT))); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !ready_o); // R8
  AST_UNIQUE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dmd_hit_vec) && $onehot0(nxt_hit_vec)); // R7
  AST_TOUCH_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_touch && fill_touch) |-> (req_set != op_set)); // R7
endmodule

bind flash_icache flash_icache_chk #(
  .ADDR_W(ADDR_W), .LINE_AW(LINE_AW), .WAYS(WAYS), .SET_B(SET_B), .LAT(LAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .req_i(req_i), .addr_i(addr_i),
  .ready_o(ready_o), .rvalid_o(rvalid_o), .fl_req_o(fl_req_o), .fl_addr_o(fl_addr_o),
  .dmd_hit_vec(dmd_hit_vec), .nxt_hit_vec(nxt_hit_vec),
  .hit_touch(hit_touch), .req_set(req_set), .fill_touch(fill_touch), .op_set(op_set)
);

// File: tb/tb_flash_icache.sv
`timescale 1ns/1ps
module tb_flash_icache;
  localparam int AW   = 10;
  localparam int LW   = 128;
  localparam int NS   = 4;
  localparam int NW   = 2;
  localparam int WS   = 5;
  localparam int LAT  = WS + 1;
  localparam int LAW  = AW - 2;
  localparam int PFS  = (LAT > 4) ? LAT - 4 : 0;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, req = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic           ready, rvalid, fl_req;
  logic [31:0]    rdata;
  logic [LAW-1:0] fl_addr;
  logic [LW-1:0]  fl_data;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  flash_icache #(.ADDR_W(AW), .LINE_W(LW), .SETS(NS), .WAYS(NW), .WAIT_ST(WS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .req_i(req), .addr_i(addr),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .fl_req_o(fl_req), .fl_addr_o(fl_addr), .fl_data_i(fl_data)
  );

  function automatic logic [31:0] wval(input int wa);
    return 32'h3C6E_F372 ^ (32'(wa) * 32'h9E37_79B1);
  endfunction

  // pipelined flash with fixed latency
  logic           pv [LAT];
  logic [LAW-1:0] pa [LAT];
  always @(posedge clk) begin
    pv[0] <= fl_req;
    pa[0] <= fl_addr;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pa[i] <= pa[i-1];
    end
  end
  always_comb begin
    for (int k = 0; k < 4; k++)
      fl_data[32*k +: 32] = (pv[LAT-1] == 1'b1) ? wval(int'(pa[LAT-1]) * 4 + k) : 32'hDEAD_BEEF;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accept edge
  task automatic fetch(input int wa, input int exp_st, input string rq,
                       input bit chk_fl = 1'b0, input int exp_fl = 0);
    int st = 0;
    logic fr;
    logic [LAW-1:0] fa;
    req  = 1'b1;
    addr = AW'(wa);
    #1;
    fr = fl_req;
    fa = fl_addr;
    while (!ready && st < 60) begin
      @(negedge clk); #1; st++;
    end
    @(negedge clk);
    if (exp_st >= 0) chk(st == exp_st, rq, $sformatf("stall cycles at word %0d", wa), st, exp_st);
    chk(rvalid === 1'b1, "R10", "rvalid after accept", rvalid, 1);
    chk(rdata === wval(wa), "R3", $sformatf("data word %0d", wa), rdata, wval(wa));
    if (chk_fl) begin
      chk(fr === 1'b1, rq, "flash request in first cycle", fr, 1);
      chk(fa == LAW'(exp_fl), rq, "flash line address", fa, exp_fl);
    end
  endtask

  task automatic idle();
    req = 1'b0;
    @(negedge clk);
    chk(rvalid === 1'b0, "R10", "rvalid low when idle", rvalid, 0);
  endtask

  task automatic do_flush();
    req   = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk(ready === 1'b0 && rvalid === 1'b0 && fl_req === 1'b0, "R1", "quiet in reset",
        {ready, rvalid, fl_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b0 && rvalid === 1'b0 && fl_req === 1'b0, "R1", "quiet after reset",
        {ready, rvalid, fl_req}, 0);

    // R2 cold miss, R4 hits in same line
    fetch(2, LAT, "R2", 1'b1, 0);
    fetch(0, 0, "R4");
    fetch(1, 0, "R4");
    fetch(3, 0, "R4");
    idle();

    // R5 full sequential sweep
    do_flush();
    for (int wa = 0; wa < (1 << AW); wa++)
      fetch(wa, (wa == 0) ? LAT : ((wa % 4 == 0) ? PFS : 0), "R5");
    idle();

    // R5 last-word stride: forward of critical word after prefetch
    do_flush();
    for (int l = 0; l < 16; l++)
      fetch(l * 4 + 3, (l == 0) ? LAT : LAT - 1, "R5");
    idle();

    // R6 branch discards pending prefetch
    do_flush();
    fetch(0, LAT, "R6", 1'b1, 0);
    fetch(9 * 4 + 1, LAT, "R6", 1'b1, 9);
    fetch(1 * 4, LAT, "R6", 1'b1, 1);
    idle();

    // R7 LRU in set 0: lines 0,4,8
    do_flush();
    begin
      int seq [8] = '{0, 4, 0, 8, 0, 4, 8, 0};
      int exs [8] = '{LAT, LAT, 0, LAT, 0, LAT, LAT, LAT};
      for (int i = 0; i < 8; i++) fetch(seq[i] * 4, exs[i], "R7");
    end
    idle();

    // R9 two-line loop
    do_flush();
    for (int p = 0; p < 4; p++)
      for (int j = 0; j < 8; j++)
        fetch(16 + j, (p == 0 && j == 0) ? LAT : ((p == 0 && j == 4) ? PFS : 0), "R9");
    idle();

    // R8 flush empties resident loop and drops pending prefetch
    do_flush();
    fetch(16, LAT, "R8", 1'b1, 4);
    fetch(30 * 4, LAT, "R8");
    do_flush();
    fetch(31 * 4, LAT, "R8", 1'b1, 31);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule